// File: doc/BRIEF.md
# Shadow Translation Cache Pair

This block puts two small first-level translation caches in front of a shared main TLB. One cache serves instruction fetches and holds four entries. The other serves data accesses and holds eight. A lookup that hits in its own cache finishes in the same cycle and never touches the main TLB. The two sides therefore compete for the main TLB only on misses.

On a miss, the side raises a request toward a single arbitrated main-TLB port. It waits for the response and writes the returned entry into a slot picked by its own round-robin pointer. It then replays the lookup, which now hits. If the main TLB reports no translation, the side ends the lookup with a fault indication and installs nothing. A single invalidate input empties both caches at once, so software never addresses individual shadow entries.

A requester holds `*_lk_valid` and `*_lk_va` stable until it sees `*_lk_done`. It drops or changes them after the clock edge at which `*_lk_done` was high.

Top module: `shadow_tlb_pair`

## Requirements
- R1: The instruction cache keeps 4 pages and the data cache keeps 8 pages resident. After that many distinct pages have been filled on a side, every one of them hits.
- R2: A hit raises `*_lk_done` combinationally in the cycle the lookup is presented and issues no main-TLB request.
- R3: A miss issues exactly one main-TLB request carrying the lookup address. After a response with `mt_rsp_hit`=1, the side installs the entry and raises `*_lk_done` with the translation in the cycle after the response.
- R4: Each side fills slots round-robin with its own pointer, which advances only on an install and is not reset by invalidation. With a full side, the next install evicts the oldest page.
- R5: A response with `mt_rsp_hit`=0 ends the lookup with `*_lk_done`=1 and `*_lk_fault`=1 for exactly one cycle, the cycle after the response. Nothing is installed, so the same address misses again.
- R6: `inv_all` high at a clock edge empties both caches by the next cycle, so every later lookup misses.
- R7: If `inv_all` arrives while a side is waiting for its main-TLB response, that response is not installed. The side requests the same address again and completes with the fresh response.
- R8: Only one main-TLB request is outstanding at a time. When both sides want the port in the same cycle, the data side is granted first (`mt_req_data`=1) and the instruction side keeps its request raised until granted.
- R9: A page with size code c (0..7) spans 2^(10+2c) bytes. The returned address is the page base with the address bits below 10+2c taken from the lookup. Execute, write and attribute bits are passed through unchanged.
- R10: After reset both caches are empty, and no `*_lk_done` or `mt_req_valid` is raised without a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inv_all | input | 1 | Empty both shadow caches |
| i_lk_valid | input | 1 | Instruction lookup request, held until done |
| i_lk_va | input | 32 | Instruction lookup address |
| i_lk_done | output | 1 | Instruction lookup complete |
| i_lk_fault | output | 1 | Instruction lookup found no translation |
| i_lk_pa | output | 32 | Instruction translated address |
| i_lk_ex | output | 1 | Instruction page execute permission |
| i_lk_wr | output | 1 | Instruction page write permission |
| i_lk_attr | output | 6 | Instruction page storage attributes |
| d_lk_valid | input | 1 | Data lookup request, held until done |
| d_lk_va | input | 32 | Data lookup address |
| d_lk_done | output | 1 | Data lookup complete |
| d_lk_fault | output | 1 | Data lookup found no translation |
| d_lk_pa | output | 32 | Data translated address |
| d_lk_ex | output | 1 | Data page execute permission |
| d_lk_wr | output | 1 | Data page write permission |
| d_lk_attr | output | 6 | Data page storage attributes |
| mt_req_valid | output | 1 | One-cycle request to the main TLB |
| mt_req_data | output | 1 | Request comes from the data side |
| mt_req_va | output | 32 | Address to translate |
| mt_rsp_valid | input | 1 | Main-TLB response strobe |
| mt_rsp_hit | input | 1 | Main TLB held a translation |
| mt_rsp_size | input | 3 | Page size code |
| mt_rsp_base | input | 32 | Page base physical address |
| mt_rsp_ex | input | 1 | Execute permission |
| mt_rsp_wr | input | 1 | Write permission |
| mt_rsp_attr | input | 6 | Storage attributes |

## Verification
Two pairs of functions can fall into the same cycle. The first pair is both sides missing at once, where the arbitration meets two simultaneous requests. The second is an invalidate landing while a fill is in flight. The bench starts both sides' lookups on the same edge and checks that the data request leaves the port first, that the instruction request goes out only after the data response, and that both translations are still correct. It also raises `inv_all` in the cycle after a data request left the port, with a random response latency that can make the response coincide with the invalidate. It judges the outcome by counting exactly two main-TLB requests for that lookup and a correct final translation.

// File: rtl/stlb_pkg.sv
// Shared constants, entry type and page arithmetic for the shadow translation caches.
// Assumes page sizes grow by a factor of four per size code, starting from MIN_OFF offset bits.
package stlb_pkg;
    parameter int AW      = 32;
    parameter int ATTR_W  = 6;
    parameter int SIZE_W  = 3;
    parameter int MIN_OFF = 10;

    typedef struct packed {
        logic [AW-1:0]     tag;
        logic [SIZE_W-1:0] size;
        logic [AW-1:0]     base;
        logic              ex;
        logic              wr;
        logic [ATTR_W-1:0] attr;
    } stlb_entry_t;

    // Mask of the in-page offset bits for a size code.
    function automatic logic [AW-1:0] off_mask(input logic [SIZE_W-1:0] sz);
        logic [63:0] one;
        int          bits;
        one  = 64'd1;
        bits = MIN_OFF + 2 * int'(sz);
        return AW'((one << bits) - 64'd1);
    endfunction

    // True when the address falls inside the page the entry describes.
    function automatic logic page_match(input logic [AW-1:0] va, input stlb_entry_t e);
        return ((va ^ e.tag) & ~off_mask(e.size)) == '0;
    endfunction

    // Page base joined with the in-page offset of the address.
    function automatic logic [AW-1:0] xlate(input logic [AW-1:0] va, input stlb_entry_t e);
        logic [AW-1:0] m;
        m = off_mask(e.size);
        return (e.base & ~m) | (va & m);
    endfunction
endpackage

// File: rtl/stlb_array.sv
// Fully associative entry store for one side: parallel match, lowest-index select,
// single-slot install and whole-array invalidate.
// Assumes the owner never installs a page that is already resident.
module stlb_array
    import stlb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv,
    input  logic [AW-1:0]    lk_va,
    input  logic             ins_en,
    input  logic [IW-1:0]    ins_idx,
    input  stlb_entry_t      ins_entry,
    output logic             hit,
    output stlb_entry_t      hit_entry,
    output logic [DEPTH-1:0] vld
);
    stlb_entry_t      ent [DEPTH];
    logic [DEPTH-1:0] match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic        v_q;
        stlb_entry_t e_q;

        // Slot state: cleared by reset or invalidate, written on install to this index.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                e_q <= '0;
            end else if (inv) begin
                v_q <= 1'b0;
            end else if (ins_en && ins_idx == IW'(g)) begin
                v_q <= 1'b1;
                e_q <= ins_entry;
            end
        end

        assign ent[g]   = e_q;
        assign vld[g]   = v_q;
        assign match[g] = v_q && page_match(lk_va, e_q);
    end

    // Select the lowest matching slot.
    always_comb begin
        hit       = |match;
        hit_entry = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (match[k]) hit_entry = ent[k];
        end
    end
endmodule

// File: rtl/stlb_side.sv
// One side of the pair: lookup, miss request, fill with a round-robin victim, replay and fault.
// Assumes the requester holds lk_valid and lk_va stable until lk_done is seen at a clock edge.
module stlb_side
    import stlb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv,
    input  logic              lk_valid,
    input  logic [AW-1:0]     lk_va,
    output logic              lk_done,
    output logic              lk_fault,
    output logic [AW-1:0]     lk_pa,
    output logic              lk_ex,
    output logic              lk_wr,
    output logic [ATTR_W-1:0] lk_attr,
    output logic              want,
    input  logic              gnt,
    input  logic              rsp_valid,
    input  logic              rsp_hit,
    input  logic [SIZE_W-1:0] rsp_size,
    input  logic [AW-1:0]     rsp_base,
    input  logic              rsp_ex,
    input  logic              rsp_wr,
    input  logic [ATTR_W-1:0] rsp_attr,
    output logic [DEPTH-1:0]  vld
);
    typedef enum logic [1:0] {S_LOOK, S_REQ, S_WAIT, S_FAULT} side_st_t;

    side_st_t    st;
    logic        stale;
    logic [IW-1:0] ptr;
    logic        hit;
    stlb_entry_t hit_e;
    logic        ins_en;
    stlb_entry_t ins_e;

    stlb_array #(.DEPTH(DEPTH)) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .inv       (inv),
        .lk_va     (lk_va),
        .ins_en    (ins_en),
        .ins_idx   (ptr),
        .ins_entry (ins_e),
        .hit       (hit),
        .hit_entry (hit_e),
        .vld       (vld)
    );

    // Lookup results, port request and install strobe.
    always_comb begin
        want     = (st == S_REQ);
        lk_fault = (st == S_FAULT);
        lk_done  = (st == S_LOOK && lk_valid && hit) || (st == S_FAULT);
        lk_pa    = (st == S_LOOK && hit) ? xlate(lk_va, hit_e) : '0;
        lk_ex    = (st == S_LOOK && hit) && hit_e.ex;
        lk_wr    = (st == S_LOOK && hit) && hit_e.wr;
        lk_attr  = (st == S_LOOK && hit) ? hit_e.attr : '0;
        ins_en   = (st == S_WAIT) && rsp_valid && rsp_hit && !stale && !inv;
        ins_e    = '{tag: lk_va, size: rsp_size, base: rsp_base,
                     ex: rsp_ex, wr: rsp_wr, attr: rsp_attr};
    end

    // Miss sequencing: request, wait, then replay or fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_LOOK;
        end else begin
            case (st)
                S_LOOK:  if (lk_valid && !hit) st <= S_REQ;
                S_REQ:   if (gnt) st <= S_WAIT;
                S_WAIT:  if (rsp_valid) st <= (rsp_hit || stale || inv) ? S_LOOK : S_FAULT;
                default: st <= S_LOOK;
            endcase
        end
    end

    // Marks a fill that an invalidate overtook while the miss was in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stale <= 1'b0;
        end else if (st == S_WAIT && rsp_valid) begin
            stale <= 1'b0;
        end else if (inv && (st == S_REQ || st == S_WAIT)) begin
            stale <= 1'b1;
        end
    end

    // Round-robin victim pointer, advanced only by an install.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (ins_en) begin
            ptr <= (ptr == IW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/stlb_port_arb.sv
// Grants the single main-TLB port to one side at a time, data side first,
// and routes the response back to the side that owns the port.
// Assumes the main TLB answers every request exactly once, at least one cycle later.
module stlb_port_arb
    import stlb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          want_d,
    input  logic [AW-1:0] va_d,
    input  logic          want_i,
    input  logic [AW-1:0] va_i,
    output logic          gnt_d,
    output logic          gnt_i,
    output logic          mt_req_valid,
    output logic          mt_req_data,
    output logic [AW-1:0] mt_req_va,
    input  logic          mt_rsp_valid,
    output logic          rsp_d,
    output logic          rsp_i
);
    logic busy;
    logic own_d;

    // Fixed priority grant while the port is idle; response steering while busy.
    always_comb begin
        gnt_d        = !busy && want_d;
        gnt_i        = !busy && want_i && !want_d;
        mt_req_valid = gnt_d || gnt_i;
        mt_req_data  = gnt_d;
        mt_req_va    = gnt_d ? va_d : va_i;
        rsp_d        = busy && own_d && mt_rsp_valid;
        rsp_i        = busy && !own_d && mt_rsp_valid;
    end

    // Port ownership from grant until response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            own_d <= 1'b0;
        end else if (mt_req_valid) begin
            busy  <= 1'b1;
            own_d <= gnt_d;
        end else if (mt_rsp_valid) begin
            busy  <= 1'b0;
        end
    end
endmodule

// File: rtl/shadow_tlb_pair.sv
// Instruction and data shadow translation caches sharing one main-TLB port.
// Assumes requesters hold their lookup until done and the main TLB returns one response per request.
module shadow_tlb_pair
    import stlb_pkg::*;
#(
    parameter int I_DEPTH = 4,
    parameter int D_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_all,
    input  logic              i_lk_valid,
    input  logic [AW-1:0]     i_lk_va,
    output logic              i_lk_done,
    output logic              i_lk_fault,
    output logic [AW-1:0]     i_lk_pa,
    output logic              i_lk_ex,
    output logic              i_lk_wr,
    output logic [ATTR_W-1:0] i_lk_attr,
    input  logic              d_lk_valid,
    input  logic [AW-1:0]     d_lk_va,
    output logic              d_lk_done,
    output logic              d_lk_fault,
    output logic [AW-1:0]     d_lk_pa,
    output logic              d_lk_ex,
    output logic              d_lk_wr,
    output logic [ATTR_W-1:0] d_lk_attr,
    output logic              mt_req_valid,
    output logic              mt_req_data,
    output logic [AW-1:0]     mt_req_va,
    input  logic              mt_rsp_valid,
    input  logic              mt_rsp_hit,
    input  logic [SIZE_W-1:0] mt_rsp_size,
    input  logic [AW-1:0]     mt_rsp_base,
    input  logic              mt_rsp_ex,
    input  logic              mt_rsp_wr,
    input  logic [ATTR_W-1:0] mt_rsp_attr
);
    logic               i_want, d_want, i_gnt, d_gnt, i_rsp, d_rsp;
    logic [I_DEPTH-1:0] i_vld;
    logic [D_DEPTH-1:0] d_vld;

    stlb_side #(.DEPTH(I_DEPTH)) u_iside (
        .clk (clk), .rst_n (rst_n), .inv (inv_all),
        .lk_valid (i_lk_valid), .lk_va (i_lk_va), .lk_done (i_lk_done),
        .lk_fault (i_lk_fault), .lk_pa (i_lk_pa), .lk_ex (i_lk_ex),
        .lk_wr (i_lk_wr), .lk_attr (i_lk_attr),
        .want (i_want), .gnt (i_gnt), .rsp_valid (i_rsp),
        .rsp_hit (mt_rsp_hit), .rsp_size (mt_rsp_size), .rsp_base (mt_rsp_base),
        .rsp_ex (mt_rsp_ex), .rsp_wr (mt_rsp_wr), .rsp_attr (mt_rsp_attr),
        .vld (i_vld)
    );

    stlb_side #(.DEPTH(D_DEPTH)) u_dside (
        .clk (clk), .rst_n (rst_n), .inv (inv_all),
        .lk_valid (d_lk_valid), .lk_va (d_lk_va), .lk_done (d_lk_done),
        .lk_fault (d_lk_fault), .lk_pa (d_lk_pa), .lk_ex (d_lk_ex),
        .lk_wr (d_lk_wr), .lk_attr (d_lk_attr),
        .want (d_want), .gnt (d_gnt), .rsp_valid (d_rsp),
        .rsp_hit (mt_rsp_hit), .rsp_size (mt_rsp_size), .rsp_base (mt_rsp_base),
        .rsp_ex (mt_rsp_ex), .rsp_wr (mt_rsp_wr), .rsp_attr (mt_rsp_attr),
        .vld (d_vld)
    );

    stlb_port_arb u_arb (
        .clk (clk), .rst_n (rst_n),
        .want_d (d_want), .va_d (d_lk_va), .want_i (i_want), .va_i (i_lk_va),
        .gnt_d (d_gnt), .gnt_i (i_gnt),
        .mt_req_valid (mt_req_valid), .mt_req_data (mt_req_data), .mt_req_va (mt_req_va),
        .mt_rsp_valid (mt_rsp_valid), .rsp_d (d_rsp), .rsp_i (i_rsp)
    );
endmodule

// File: rtl/stlb_checker.sv
// Temporal checks on the shadow pair, attached to every instance through bind.
module stlb_checker #(
    parameter int I_DEPTH = 4,
    parameter int D_DEPTH = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               inv_all,
    input logic               i_want,
    input logic               i_gnt,
    input logic               d_want,
    input logic               mt_req_valid,
    input logic               mt_req_data,
    input logic               mt_rsp_valid,
    input logic               i_lk_done,
    input logic               i_lk_fault,
    input logic               d_lk_done,
    input logic               d_lk_fault,
    input logic [I_DEPTH-1:0] i_vld,
    input logic [D_DEPTH-1:0] d_vld
);
    logic outst;

    // Tracks whether a main-TLB request is waiting for its response.
    always_ff @(posedge clk) begin
        if (!rst_n)            outst <= 1'b0;
        else if (mt_req_valid) outst <= 1'b1;
        else if (mt_rsp_valid) outst <= 1'b0;
    end

    p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mt_req_valid |-> !outst);

    p_data_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (d_want && i_want && mt_req_valid) |-> mt_req_data);

    p_instr_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (i_want && !i_gnt) |=> i_want);

    p_hit_no_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (d_lk_done && !d_lk_fault) |-> !(mt_req_valid && mt_req_data));

    p_fault_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (i_lk_fault |-> i_lk_done) and (d_lk_fault |-> d_lk_done));

    p_fault_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        d_lk_fault |=> !d_lk_fault);

    p_inv_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (i_vld == '0 && d_vld == '0));
endmodule

bind shadow_tlb_pair stlb_checker #(.I_DEPTH(I_DEPTH), .D_DEPTH(D_DEPTH)) u_chk (
    .clk (clk), .rst_n (rst_n), .inv_all (inv_all),
    .i_want (i_want), .i_gnt (i_gnt), .d_want (d_want),
    .mt_req_valid (mt_req_valid), .mt_req_data (mt_req_data), .mt_rsp_valid (mt_rsp_valid),
    .i_lk_done (i_lk_done), .i_lk_fault (i_lk_fault),
    .d_lk_done (d_lk_done), .d_lk_fault (d_lk_fault),
    .i_vld (i_vld), .d_vld (d_vld)
);

// File: tb/shadow_tlb_pair_test.sv
module shadow_tlb_pair_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inv_all = 1'b0;
    logic        i_lk_valid = 1'b0, d_lk_valid = 1'b0;
    logic [31:0] i_lk_va = '0, d_lk_va = '0;
    logic        i_lk_done, i_lk_fault, i_lk_ex, i_lk_wr;
    logic        d_lk_done, d_lk_fault, d_lk_ex, d_lk_wr;
    logic [31:0] i_lk_pa, d_lk_pa;
    logic [5:0]  i_lk_attr, d_lk_attr;
    logic        mt_req_valid, mt_req_data;
    logic [31:0] mt_req_va;
    logic        mt_rsp_valid = 1'b0, mt_rsp_hit = 1'b0, mt_rsp_ex = 1'b0, mt_rsp_wr = 1'b0;
    logic [2:0]  mt_rsp_size = '0;
    logic [31:0] mt_rsp_base = '0;
    logic [5:0]  mt_rsp_attr = '0;

    int checks = 0, fails = 0, cyc = 0;
    int reqs [2];
    int order [64];
    int n_order = 0;
    int rsp_cyc = 0;
    bit pend = 1'b0;
    int lat = 0;
    logic [31:0] pend_va = '0;

    bit          mv [2][8];
    logic [31:0] mtag [2][8];
    int          mptr [2];
    int          mdepth [2] = '{4, 8};

    shadow_tlb_pair uut (.*);

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] omask(input logic [2:0] c);
        return (32'h1 << (10 + 2 * int'(c))) - 32'h1;
    endfunction

    // Main TLB model: addresses with bit 31 clear are mapped, size code in bits 30:28.
    function automatic void mt_model(input logic [31:0] va, output bit h, output logic [2:0] sz,
                                     output logic [31:0] base, output bit ex, output bit wr,
                                     output logic [5:0] at);
        h    = !va[31];
        sz   = va[30:28];
        base = (va ^ 32'h0F00_0000) & ~omask(va[30:28]);
        ex   = va[28];
        wr   = va[29];
        at   = {va[30:28], ~va[30:28]};
    endfunction

    function automatic logic [31:0] pg(input int code, input int k, input logic [31:0] off);
        logic [31:0] b;
        b = {1'b0, code[2:0], k[3:0], 24'h0};
        return b | (off & omask(code[2:0]));
    endfunction

    task automatic chk(input bit ok, input string r, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    // Behavioural main-TLB responder with a random latency of 1 to 4 cycles.
    always @(negedge clk) begin
        bit h, ex, wr;
        logic [2:0] sz;
        logic [31:0] base;
        logic [5:0] at;
        mt_rsp_valid = 1'b0;
        if (pend) begin
            lat--;
            if (lat == 0) begin
                mt_model(pend_va, h, sz, base, ex, wr, at);
                mt_rsp_hit = h; mt_rsp_size = sz; mt_rsp_base = base;
                mt_rsp_ex = ex; mt_rsp_wr = wr; mt_rsp_attr = at;
                mt_rsp_valid = 1'b1;
                rsp_cyc = cyc;
                pend = 1'b0;
            end
        end else if (rst_n && mt_req_valid) begin
            pend = 1'b1;
            pend_va = mt_req_va;
            lat = 1 + int'($urandom % 4);
            reqs[mt_req_data ? 1 : 0]++;
            if (n_order < 64) order[n_order] = mt_req_data ? 1 : 0;
            n_order++;
        end
    end

    function automatic bit model_hit(input int s, input logic [31:0] va);
        for (int k = 0; k < mdepth[s]; k++)
            if (mv[s][k] && ((va ^ mtag[s][k]) & ~omask(mtag[s][k][30:28])) == 0) return 1'b1;
        return 1'b0;
    endfunction

    task automatic model_clear();
        for (int s = 0; s < 2; s++)
            for (int k = 0; k < 8; k++) mv[s][k] = 1'b0;
    endtask

    // One lookup on side s (0 instruction, 1 data) checked against the model.
    task automatic lookup(input int s, input logic [31:0] va, input string r,
                          input int extra, input bit timing);
        bit exp_hit, h, ex, wr, a_done, a_fault, a_ex, a_wr;
        logic [2:0] sz;
        logic [31:0] base, exp_pa, a_pa;
        logic [5:0] at, a_attr;
        int r0, waited, dcyc;
        exp_hit = model_hit(s, va);
        mt_model(va, h, sz, base, ex, wr, at);
        exp_pa = (base & ~omask(sz)) | (va & omask(sz));
        r0 = reqs[s];
        waited = 0;
        @(negedge clk);
        if (s == 0) begin i_lk_valid = 1'b1; i_lk_va = va; end
        else        begin d_lk_valid = 1'b1; d_lk_va = va; end
        forever begin
            #1;
            a_done = (s == 0) ? i_lk_done : d_lk_done;
            if (a_done) break;
            @(negedge clk);
            waited++;
        end
        a_fault = (s == 0) ? i_lk_fault : d_lk_fault;
        a_pa    = (s == 0) ? i_lk_pa : d_lk_pa;
        a_ex    = (s == 0) ? i_lk_ex : d_lk_ex;
        a_wr    = (s == 0) ? i_lk_wr : d_lk_wr;
        a_attr  = (s == 0) ? i_lk_attr : d_lk_attr;
        dcyc = cyc;
        @(posedge clk);
        #1;
        if (s == 0) i_lk_valid = 1'b0; else d_lk_valid = 1'b0;
        chk(a_fault == !h, r, "fault flag", a_fault, !h);
        if (h) begin
            chk(a_pa == exp_pa && a_ex == ex && a_wr == wr && a_attr == at, r,
                "translation", {a_pa, a_attr, a_ex, a_wr}, {exp_pa, at, ex, wr});
        end
        chk(reqs[s] - r0 == (exp_hit ? 0 : 1 + extra), r, "main-TLB requests",
            reqs[s] - r0, exp_hit ? 0 : 1 + extra);
        if (exp_hit) chk(waited == 0, r, "hit latency", waited, 0);
        else if (timing) chk(dcyc == rsp_cyc + 1, r, "done after response", dcyc, rsp_cyc + 1);
        if (!exp_hit && h) begin
            mv[s][mptr[s]] = 1'b1;
            mtag[s][mptr[s]] = va;
            mptr[s] = (mptr[s] + 1) % mdepth[s];
        end
    endtask

    task automatic pulse_inv();
        @(negedge clk);
        inv_all = 1'b1;
        model_clear();
        @(negedge clk);
        inv_all = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        reqs[0] = 0; reqs[1] = 0; mptr[0] = 0; mptr[1] = 0;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk(!i_lk_done && !d_lk_done && !mt_req_valid, "R10", "idle after reset",
            {i_lk_done, d_lk_done, mt_req_valid}, 0);

        // R3 R9: fill the data side with one page of every size code, then hit all of them (R1 R2).
        for (int k = 0; k < 8; k++) lookup(1, pg(k, k, 32'h0), "R3", 0, 1'b1);
        for (int k = 0; k < 8; k++) lookup(1, pg(k, k, 32'hFFFF_FFFF), "R1", 0, 1'b0);
        for (int k = 0; k < 8; k++) lookup(1, pg(k, k, 32'h0055_5555), "R9", 0, 1'b0);

        // R1 R4: instruction side capacity, then eviction of the oldest page.
        for (int k = 0; k < 4; k++) lookup(0, pg(k + 2, k, 32'h0), "R3", 0, 1'b1);
        for (int k = 0; k < 4; k++) lookup(0, pg(k + 2, k, 32'h1234), "R1", 0, 1'b0);
        lookup(0, pg(1, 9, 32'h0), "R4", 0, 1'b1);
        lookup(0, pg(2, 0, 32'h40), "R4", 0, 1'b1);
        lookup(0, pg(4, 2, 32'h0), "R4", 0, 1'b0);
        lookup(1, pg(0, 12, 32'h0), "R4", 0, 1'b1);
        lookup(1, pg(0, 0, 32'h3FF), "R4", 0, 1'b1);

        // R5: unmapped addresses fault and are never cached.
        lookup(1, 32'h8000_1000, "R5", 0, 1'b1);
        lookup(1, 32'h8000_1000, "R5", 0, 1'b1);
        lookup(0, 32'hC123_0000, "R5", 0, 1'b1);

        // R6: invalidate, then previously resident pages miss; R4 pointer keeps going.
        pulse_inv();
        lookup(1, pg(3, 3, 32'h0), "R6", 0, 1'b1);
        lookup(0, pg(3, 1, 32'h0), "R6", 0, 1'b1);
        for (int k = 0; k < 9; k++) lookup(1, pg(k % 8, k + 4, 32'h10), "R4", 0, 1'b1);

        // R7: invalidate while the data fill is in flight forces a second request.
        fork
            lookup(1, pg(5, 15, 32'h77), "R7", 1, 1'b1);
            begin
                forever begin
                    @(negedge clk);
                    #2;
                    if (pend) break;
                end
                pulse_inv();
            end
        join

        // R8: both sides miss together; the data side is served first.
        for (int t = 0; t < 4; t++) begin
            int n0;
            n0 = n_order;
            fork
                lookup(0, pg(t, 10 + t, 32'h0), "R8", 0, 1'b0);
                lookup(1, pg(t + 4, 10 + t, 32'h0), "R8", 0, 1'b0);
            join
            chk(n_order == n0 + 2 && order[n0 % 64] == 1 && order[(n0 + 1) % 64] == 0, "R8",
                "grant order", order[n0 % 64], 1);
        end

        // R9 sweep: every size code at the first, middle and last byte of a page.
        pulse_inv();
        for (int c = 0; c < 8; c++) begin
            lookup(1, pg(c, 6, 32'h0), "R9", 0, 1'b1);
            lookup(1, pg(c, 6, omask(c[2:0]) >> 1), "R9", 0, 1'b0);
            lookup(1, pg(c, 6, 32'hFFFF_FFFF), "R9", 0, 1'b0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule